// File: doc/BRIEF.md
# Interlocked Two-Wire Parallel Port Controller

This block gives an 8-bit parallel port a fully interlocked two-wire handshake. It uses one strobe input from the peer (`hs_in`) and one strobe output to the peer (`hs_out`). The `dir_out` pin selects the direction, and the meaning of the two wires follows it.

When the port receives, the peer lowers its data-available strobe on `hs_in`. The block captures the port pins and drops its ready line on `hs_out` to acknowledge the capture. It then offers the byte to the core on a valid/ready stream. When the port transmits, the block takes a byte from the core on a second valid/ready stream and drives it onto the pins. After a lead time it lowers data-available on `hs_out`. It raises the strobe again once the peer has pulled its ready line (`hs_in`) low and a minimum strobe width has passed. The block accepts no new byte until the peer's ready line is high again.

Both streams apply back-pressure:
- The receive stream holds `rx_valid` and `rx_data` until the core asserts `rx_ready`. The port stays unacknowledged, with ready low, until that happens.
- The transmit stream lowers `tx_ready` for the whole exchange, so the core cannot push a byte into a transfer that is already in progress.

Both handshake inputs and the data pins pass through a synchronizer of `SYNC_STAGES` flops before any logic acts on them. The direction may only change while reset is asserted.

Top module: `hsport_ctrl`

## Requirements
- R1: After reset in receive mode, `hs_out` is 1, `rx_valid` is 0, `tx_busy` is 0 and `port_oe` is 0.
- R2: In receive mode, a fall of `hs_in` (data-available, active low) while `hs_out` is high has two effects on the (SYNC_STAGES+1)-th rising edge after the fall, and not before. First, the byte on `port_din` is captured into `rx_data`. Second, `rx_valid` goes to 1 and `hs_out` (ready) goes to 0 on that same edge. The pins must stay unchanged until then.
- R3: In receive mode, `hs_out` returns to 1 only after two things have happened: `hs_in` is high again, and the byte has been taken (`rx_valid` and `rx_ready` both 1 on an edge). Either of the two may happen first.
- R4: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` does not change. Later changes on `port_din` do not alter a captured byte.
- R5: In receive mode, a fall of `hs_in` while `hs_out` is low is ignored. No new byte is captured and the pending byte is kept.
- R6: In transmit mode, `tx_ready` is 1 only while no transfer is in progress. A byte is accepted on an edge where `tx_valid` and `tx_ready` are both 1. From that edge on, the byte is driven on `port_dout` with `port_oe` at 1, and `tx_busy` is 1. `hs_out` (data-available, active low) falls exactly LEAD edges later, provided the synchronized `hs_in` is high.
- R7: In transmit mode, `hs_out` stays low for at least MIN_LOW clock cycles. It rises only after the synchronized `hs_in` (peer ready) has gone low.
- R8: In transmit mode, after `hs_out` rises, `tx_busy` stays 1 and `tx_ready` stays 0 until the synchronized `hs_in` is high again. No new byte can be accepted before then.
- R9: While `tx_busy` is 1, `tx_valid` is ignored: `port_dout` does not change and `tx_ready` is 0.
- R10: In receive mode, `port_oe` is 0 and `tx_ready` is 0. In transmit mode, `port_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_out | input | 1 | 1 selects transmit mode, 0 selects receive mode; change only in reset |
| port_din | input | DW | Port pins as seen by the block |
| port_dout | output | DW | Byte driven onto the port in transmit mode |
| port_oe | output | 1 | Output enable for the port pins |
| hs_in | input | 1 | Peer strobe: data-available in receive mode, ready in transmit mode |
| hs_out | output | 1 | Own strobe: ready in receive mode, data-available (active low) in transmit mode |
| rx_valid | output | 1 | A received byte is waiting |
| rx_ready | input | 1 | Core takes the received byte |
| rx_data | output | DW | Received byte |
| tx_valid | input | 1 | Core offers a byte to send |
| tx_ready | output | 1 | Block accepts a byte this cycle |
| tx_data | input | DW | Byte to send |
| tx_busy | output | 1 | A transmit exchange is in progress |

## Verification
The bench builds the block with an 8-bit port, a two-flop synchronizer, LEAD of 2 and MIN_LOW of 4. The short strobe floor lets a single run separate two cases. In one, the minimum-width rule alone keeps data-available low, because the peer answers at once. In the other, the peer's late ready keeps it low. The two-flop depth makes the exact acknowledgement latency a fixed three edges that the bench can check cycle by cycle. Both receive orderings are reached in a few dozen cycles per byte: the core reading before the strobe returns high, and after it.

// File: rtl/hsport_pkg.sv
package hsport_pkg;

  typedef enum logic [0:0] {
    RX_ARMED = 1'b0,
    RX_HELD  = 1'b1
  } rx_state_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_LEAD  = 2'd1,
    TX_LOW   = 2'd2,
    TX_DRAIN = 2'd3
  } tx_state_t;

endpackage

// File: rtl/hsport_sync.sv
module hsport_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hsport_rx.sv
module hsport_rx
  import hsport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dav_s,
  input  logic [DW-1:0] din_s,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rdy_o
);

  rx_state_t state;
  logic      dav_q;
  logic      dav_fall;

  // edge seen only after synchronization
  assign dav_fall = dav_q & ~dav_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_ARMED;
      dav_q    <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      dav_q <= dav_s;
      if (!en) begin
        state    <= RX_ARMED;
        rx_valid <= 1'b0;
      end else begin
        if (rx_valid && rx_ready) rx_valid <= 1'b0;
        case (state)
          RX_ARMED: begin
            if (dav_fall) begin
              rx_data  <= din_s;
              rx_valid <= 1'b1;
              state    <= RX_HELD;
            end
          end
          RX_HELD: begin
            // re-arm once the strobe is back high and the core holds nothing
            if (dav_s && !rx_valid) state <= RX_ARMED;
          end
          default: state <= RX_ARMED;
        endcase
      end
    end
  end

  assign rdy_o = (state == RX_ARMED);

endmodule

// File: rtl/hsport_tx.sv
module hsport_tx
  import hsport_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LEAD    = 2,
  parameter int MIN_LOW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rdy_s,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          tx_busy,
  output logic          dav_o,
  output logic [DW-1:0] dout
);

  localparam int              SPAN      = (LEAD > MIN_LOW) ? LEAD : MIN_LOW;
  localparam int              CW        = $clog2(SPAN + 1);
  localparam logic [CW-1:0]   LEAD_LAST = CW'(LEAD - 1);
  localparam logic [CW-1:0]   LOW_LAST  = CW'(MIN_LOW - 1);

  tx_state_t     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      dav_o <= 1'b1;
      dout  <= '0;
      cnt   <= '0;
    end else if (!en) begin
      state <= TX_IDLE;
      dav_o <= 1'b1;
      cnt   <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (tx_valid) begin
            dout  <= tx_data;
            cnt   <= '0;
            state <= TX_LEAD;
          end
        end
        TX_LEAD: begin
          if (cnt >= LEAD_LAST && rdy_s) begin
            dav_o <= 1'b0;
            cnt   <= '0;
            state <= TX_LOW;
          end else if (cnt < LEAD_LAST) begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_LOW: begin
          if (cnt >= LOW_LAST && !rdy_s) begin
            dav_o <= 1'b1;
            state <= TX_DRAIN;
          end else if (cnt < LOW_LAST) begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_DRAIN: begin
          if (rdy_s) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign tx_ready = en && (state == TX_IDLE);
  assign tx_busy  = (state != TX_IDLE);

endmodule

// File: rtl/hsport_ctrl.sv
module hsport_ctrl #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD        = 2,
  parameter int MIN_LOW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_out,
  input  logic [DW-1:0] port_din,
  output logic [DW-1:0] port_dout,
  output logic          port_oe,
  input  logic          hs_in,
  output logic          hs_out,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          tx_busy
);

  logic          hs_s;
  logic [DW-1:0] din_s;
  logic          rx_rdy;
  logic          tx_dav;

  hsport_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_hs (
    .clk (clk),
    .rst_n (rst_n),
    .d   (hs_in),
    .q   (hs_s)
  );

  hsport_sync #(.W(DW), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_dat (
    .clk (clk),
    .rst_n (rst_n),
    .d   (port_din),
    .q   (din_s)
  );

  hsport_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (!dir_out),
    .dav_s    (hs_s),
    .din_s    (din_s),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rdy_o    (rx_rdy)
  );

  hsport_tx #(.DW(DW), .LEAD(LEAD), .MIN_LOW(MIN_LOW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (dir_out),
    .rdy_s    (hs_s),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .tx_busy  (tx_busy),
    .dav_o    (tx_dav),
    .dout     (port_dout)
  );

  assign hs_out  = dir_out ? tx_dav : rx_rdy;
  assign port_oe = dir_out;

endmodule

// File: rtl/hsport_chk.sv
module hsport_chk #(
  parameter int DW      = 8,
  parameter int MIN_LOW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_out,
  input logic          hs_out,
  input logic          port_oe,
  input logic [DW-1:0] port_dout,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          tx_busy
);

  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                low_cnt <= '0;
    else if (dir_out && !hs_out) low_cnt <= low_cnt + 32'd1;
    else                       low_cnt <= '0;
  end

  // R2
  ack_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && $fell(hs_out)) |-> rx_valid);

  // R3
  rearm_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && $rose(hs_out)) |-> !rx_valid);

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R6
  data_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_out && $fell(hs_out)) |-> (port_oe && $stable(port_dout)));

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_out && $rose(hs_out)) |-> (low_cnt >= 32'(MIN_LOW)));

  // R9
  busy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_out && tx_busy && $past(tx_busy)) |-> $stable(port_dout));

endmodule

bind hsport_ctrl hsport_chk #(.DW(DW), .MIN_LOW(MIN_LOW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_out   (dir_out),
  .hs_out    (hs_out),
  .port_oe   (port_oe),
  .port_dout (port_dout),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .tx_busy   (tx_busy)
);

// File: tb/hsport_ctrl_tb_top.sv
module hsport_ctrl_tb_top;

  localparam int DW      = 8;
  localparam int SYNC    = 2;
  localparam int LEAD    = 2;
  localparam int MIN_LOW = 4;

  // receive rows: {read_before_strobe_returns, data}
  localparam logic [3:0][8:0] RX_VEC = {
    {1'b1, 8'h3C}, {1'b0, 8'hFF}, {1'b1, 8'h00}, {1'b0, 8'hA5}
  };
  // transmit rows: {peer_delay[3:0], data}
  localparam logic [3:0][11:0] TX_VEC = {
    {4'd9, 8'h81}, {4'd0, 8'h7E}, {4'd2, 8'h00}, {4'd0, 8'hC3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dir_out = 1'b0;
  logic [DW-1:0] port_din = '0;
  logic [DW-1:0] port_dout;
  logic          port_oe;
  logic          hs_in = 1'b1;
  logic          hs_out;
  logic          rx_valid;
  logic          rx_ready = 1'b0;
  logic [DW-1:0] rx_data;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic          tx_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hsport_ctrl #(.DW(DW), .SYNC_STAGES(SYNC), .LEAD(LEAD), .MIN_LOW(MIN_LOW)) dut_i (
    .clk (clk), .rst_n (rst_n), .dir_out (dir_out),
    .port_din (port_din), .port_dout (port_dout), .port_oe (port_oe),
    .hs_in (hs_in), .hs_out (hs_out),
    .rx_valid (rx_valid), .rx_ready (rx_ready), .rx_data (rx_data),
    .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_data (tx_data),
    .tx_busy (tx_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; dir_out = mode; hs_in = 1'b1; rx_ready = 1'b0; tx_valid = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic core_read();
    rx_ready = 1'b1;
    cyc(1);
    rx_ready = 1'b0;
  endtask

  task automatic rx_xfer(input logic [DW-1:0] d, input logic early);
    port_din = d; hs_in = 1'b0;
    cyc(4);
    chk("R2 ready low", 32'(hs_out), 0);
    chk("R2 valid", 32'(rx_valid), 1);
    chk("R2 data", 32'(rx_data), 32'(d));
    port_din = ~d;
    if (early) begin
      core_read();
      chk("R3 taken", 32'(rx_valid), 0);
      cyc(3);
      chk("R3 ready held while strobe low", 32'(hs_out), 0);
      hs_in = 1'b1;
      cyc(4);
      chk("R3 rearm", 32'(hs_out), 1);
    end else begin
      hs_in = 1'b1;
      cyc(4);
      chk("R3 ready held while byte pending", 32'(hs_out), 0);
      chk("R4 valid held", 32'(rx_valid), 1);
      chk("R4 data held", 32'(rx_data), 32'(d));
      core_read();
      cyc(3);
      chk("R3 rearm", 32'(hs_out), 1);
      chk("R3 empty", 32'(rx_valid), 0);
    end
  endtask

  task automatic tx_xfer(input logic [DW-1:0] d, input int dly);
    int k;
    int w;
    chk("R6 ready idle", 32'(tx_ready), 1);
    tx_valid = 1'b1; tx_data = d;
    cyc(1);
    tx_valid = 1'b0;
    chk("R6 busy", 32'(tx_busy), 1);
    chk("R6 data", 32'(port_dout), 32'(d));
    chk("R6 strobe still high", 32'(hs_out), 1);
    k = 0;
    while (hs_out && k < 50) begin cyc(1); k++; end
    chk("R6 lead", 32'(k), 32'(LEAD));
    w = 1;
    for (int j = 0; j < dly; j++) begin
      cyc(1);
      if (!hs_out) w++;
    end
    chk("R7 low while peer ready", 32'(hs_out), 0);
    hs_in = 1'b0;
    while (!hs_out && w < 60) begin cyc(1); if (!hs_out) w++; end
    chk("R7 min width", 32'(w >= MIN_LOW), 1);
    if (dly == 0) chk("R7 exact floor", 32'(w), 32'(MIN_LOW));
    else chk("R7 waits peer", 32'(w > dly), 1);
    cyc(3);
    chk("R8 busy in drain", 32'(tx_busy), 1);
    chk("R8 no ready in drain", 32'(tx_ready), 0);
    tx_valid = 1'b1; tx_data = ~d;
    cyc(2);
    chk("R9 write ignored", 32'(port_dout), 32'(d));
    tx_valid = 1'b0;
    hs_in = 1'b1;
    cyc(4);
    chk("R8 idle after peer", 32'(tx_busy), 0);
    chk("R8 ready after peer", 32'(tx_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R1 reset state
    chk("R1 ready", 32'(hs_out), 1);
    chk("R1 valid", 32'(rx_valid), 0);
    chk("R1 busy", 32'(tx_busy), 0);
    chk("R1 oe", 32'(port_oe), 0);
    // R10 receive mode blocks transmit side
    tx_valid = 1'b1;
    cyc(1);
    chk("R10 tx_ready", 32'(tx_ready), 0);
    chk("R10 oe", 32'(port_oe), 0);
    tx_valid = 1'b0;

    for (int i = 0; i < 4; i++) rx_xfer(RX_VEC[i][7:0], RX_VEC[i][8]);

    // R2 exact latency: ack on the third edge
    port_din = 8'h5A; hs_in = 1'b0;
    cyc(2);
    chk("R2 not before", 32'(hs_out), 1);
    cyc(1);
    chk("R2 third edge", 32'(hs_out), 0);
    chk("R2 latency data", 32'(rx_data), 32'h5A);
    hs_in = 1'b1;
    cyc(3);
    // R5 strobe fall while ready low is ignored
    port_din = 8'h11; hs_in = 1'b0;
    cyc(4);
    hs_in = 1'b1;
    cyc(4);
    chk("R5 data kept", 32'(rx_data), 32'h5A);
    chk("R5 still pending", 32'(rx_valid), 1);
    core_read();
    cyc(3);
    chk("R5 no extra byte", 32'(rx_valid), 0);
    chk("R5 rearm", 32'(hs_out), 1);

    do_reset(1'b1);
    chk("R10 oe tx", 32'(port_oe), 1);
    for (int i = 0; i < 4; i++) tx_xfer(TX_VEC[i][7:0], int'(TX_VEC[i][11:8]));

    // R8 peer ready low before a byte: strobe must not fall
    hs_in = 1'b0;
    cyc(3);
    tx_valid = 1'b1; tx_data = 8'h99;
    cyc(1);
    tx_valid = 1'b0;
    cyc(6);
    chk("R8 wait for peer ready", 32'(hs_out), 1);
    hs_in = 1'b1;
    cyc(5);
    chk("R8 strobe after peer ready", 32'(hs_out), 0);
    hs_in = 1'b0;
    cyc(8);
    hs_in = 1'b1;
    cyc(4);
    chk("R8 done", 32'(tx_busy), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule